// File: doc/BRIEF.md
# Touch-Panel Converter Command Port

This block is the device-side serial port of a sampling converter that serves a resistive touch panel. A host drives chip select, a serial clock and a data line; the port waits for a start bit, collects a control byte, and from it sets the channel, the result width, the reference mode and the power-down setting. These decoded fields go straight to the switch sequencer. The port then marks an acquisition window and a conversion window, raises a busy flag for one serial clock, and shifts the converter's parallel result out MSB first.

The serial pins are sampled in the system clock domain: the port resynchronises chip select, serial clock and data, and acts on the detected serial-clock edges. Input data is taken on rising edges and output data changes on falling edges. The data and busy outputs each come with an output-enable, which stays low while chip select is high so that the pad ring can float them. The next control byte may overlap the tail of the result being shifted, so frames can shrink to 15 serial clocks for 12-bit results or 11 for 8-bit results; longer frames padded with zeros (16 or 24 clocks) work the same way.

Top module: `tsc_serial_port`

## Requirements
- R1: While cs_ni is high, dout_oe_o and busy_oe_o are low and busy_o, acq_o and conv_o are low; raising cs_ni mid-frame aborts it, and the next frame after cs_ni falls again needs a fresh start bit.
- R2: DIN zeros received while no frame is open are ignored; the first 1 is taken as the start bit, on whatever serial clock it falls.
- R3: The control byte is, first bit received first: start bit (1), channel bits 2..0, a width bit (1 selects 8-bit, 0 selects 12-bit), a reference bit (1 single-ended, 0 differential), power-down bits 1..0; chan_o, mode8_o, single_o and pd_o take these values after the eighth bit is captured and hold them until the next complete control byte, also across chip-select deassertion.
- R4: busy_o rises on the falling edge of the eighth clock counted from the start bit and falls on the falling edge of the ninth.
- R5: In 12-bit mode dout_o presents result_i[11] after the falling edge of the ninth clock and one lower bit after each following falling edge, down to result_i[0].
- R6: In 8-bit mode dout_o presents result_i[11:4] MSB first with the same start position.
- R7: After the last result bit, dout_o is 0 until the next result starts or chip select rises.
- R8: acq_o is high from the falling edge of the fifth clock to that of the eighth (three clocks); conv_o is high from the falling edge of the eighth clock for 12 clocks in 12-bit mode or 8 clocks in 8-bit mode; the two are never high together.
- R9: Within an open frame a new start bit is accepted no earlier than clock 16 (12-bit) or clock 12 (8-bit), counting the current start bit as clock 1; a 1 on DIN before that is ignored, giving 15- and 11-clock back-to-back framing.
- R10: Frames of 16 and 24 clocks, with zeros on DIN after the control byte, produce the same result timing as the shortest framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select from host, active low |
| dclk_i | input | 1 | Serial clock from host |
| din_i | input | 1 | Serial data from host |
| result_i | input | RES_W | Parallel result from the converter |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for dout_o |
| busy_o | output | 1 | Busy flag |
| busy_oe_o | output | 1 | Output enable for busy_o |
| acq_o | output | 1 | Acquisition window |
| conv_o | output | 1 | Conversion window |
| chan_o | output | 3 | Decoded channel select |
| mode8_o | output | 1 | Decoded width, 1 = 8-bit |
| single_o | output | 1 | Decoded reference mode, 1 = single-ended |
| pd_o | output | 2 | Decoded power-down setting |

## Verification
On every cycle the assertions check that chip select clears busy, acquisition and conversion, that acquisition and conversion never overlap, that busy rises exactly as acquisition ends and sits inside conversion, that the MSB leaving the port equals the converter's result when busy falls, and that the decoded fields only move when a control byte completes. Only the bench's scenarios show the clock-accurate placement of each result bit, the zero tail, the leading-zero skip, the rejection of early start bits in 15- and 11-clock framing, and recovery after an aborted frame.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef struct packed {
    logic [2:0] chan;
    logic       mode8;
    logic       single;
    logic [1:0] pd;
  } cmd_t;

  localparam int CTRL_BITS = 7;  // bits after the start bit
endpackage

// File: rtl/tsp_in_sync.sv
module tsp_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dclk_i,
  input  logic cs_ni,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_o,
  output logic din_o
);
  // bit order {dclk, cs_n, din}
  localparam logic [2:0] RST_VAL = 3'b010;

  logic [2:0] stg [STAGES];
  logic       dclk_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= {dclk_i, cs_ni, din_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dclk_d <= 1'b0;
    else         dclk_d <= stg[STAGES-1][2];

  assign rise_o = stg[STAGES-1][2] & ~dclk_d;
  assign fall_o = ~stg[STAGES-1][2] & dclk_d;
  assign cs_o   = stg[STAGES-1][1];
  assign din_o  = stg[STAGES-1][0];
endmodule

// File: rtl/tsp_cmd_rx.sv
module tsp_cmd_rx
  import tsp_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int LOW_W    = 8,
  parameter int ACQ_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rise_i,
  input  logic din_i,
  output cmd_t cmd_o,
  output logic cmd_done_o,
  output logic acq_go_o
);
  localparam int FRAME_HI = RES_W + 3;
  localparam int FRAME_LO = LOW_W + 3;
  localparam int CNT_W    = $clog2(FRAME_HI + 1);
  localparam int BIT_W    = $clog2(CTRL_BITS + 1);
  localparam logic [BIT_W-1:0] ACQ_AT  = BIT_W'(CTRL_BITS - ACQ_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_AT = BIT_W'(CTRL_BITS - 1);

  logic                 in_byte_q, idle_q;
  logic [BIT_W-1:0]     bit_cnt_q;
  logic [CTRL_BITS-2:0] sh_q;
  logic [CNT_W-1:0]     frame_cnt_q;
  logic                 can_start;

  assign can_start = idle_q ||
    (frame_cnt_q >= (cmd_o.mode8 ? CNT_W'(FRAME_LO) : CNT_W'(FRAME_HI)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_byte_q   <= 1'b0;
      idle_q      <= 1'b1;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      frame_cnt_q <= '0;
      cmd_o       <= '0;
      cmd_done_o  <= 1'b0;
      acq_go_o    <= 1'b0;
    end else if (clr_i) begin
      in_byte_q   <= 1'b0;
      idle_q      <= 1'b1;
      bit_cnt_q   <= '0;
      frame_cnt_q <= '0;
      cmd_done_o  <= 1'b0;
      acq_go_o    <= 1'b0;
    end else begin
      cmd_done_o <= 1'b0;
      acq_go_o   <= 1'b0;
      if (rise_i) begin
        if (!in_byte_q) begin
          if (can_start && din_i) begin
            in_byte_q   <= 1'b1;
            idle_q      <= 1'b0;
            bit_cnt_q   <= '0;
            frame_cnt_q <= CNT_W'(1);
          end else if (frame_cnt_q < CNT_W'(FRAME_HI)) begin
            frame_cnt_q <= frame_cnt_q + 1'b1;
          end
        end else begin
          sh_q        <= {sh_q[CTRL_BITS-3:0], din_i};
          bit_cnt_q   <= bit_cnt_q + 1'b1;
          frame_cnt_q <= frame_cnt_q + 1'b1;
          if (bit_cnt_q == ACQ_AT) acq_go_o <= 1'b1;
          if (bit_cnt_q == LAST_AT) begin
            cmd_o      <= cmd_t'({sh_q, din_i});
            cmd_done_o <= 1'b1;
            in_byte_q  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tsp_result_tx.sv
module tsp_result_tx #(
  parameter int RES_W = 12,
  parameter int LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fall_i,
  input  logic             acq_go_i,
  input  logic             cmd_done_i,
  input  logic             mode8_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             busy_o,
  output logic             acq_o,
  output logic             conv_o
);
  localparam int CW = $clog2(RES_W + 1);

  logic             acq_pend_q, done_pend_q, load_pend_q, mode8_q;
  logic [RES_W-1:0] sh_q;
  logic [CW-1:0]    conv_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acq_pend_q  <= 1'b0;
      done_pend_q <= 1'b0;
      load_pend_q <= 1'b0;
      mode8_q     <= 1'b0;
      sh_q        <= '0;
      conv_cnt_q  <= '0;
      busy_o      <= 1'b0;
      acq_o       <= 1'b0;
    end else if (clr_i) begin
      acq_pend_q  <= 1'b0;
      done_pend_q <= 1'b0;
      load_pend_q <= 1'b0;
      sh_q        <= '0;
      conv_cnt_q  <= '0;
      busy_o      <= 1'b0;
      acq_o       <= 1'b0;
    end else begin
      if (acq_go_i)   acq_pend_q  <= 1'b1;
      if (cmd_done_i) done_pend_q <= 1'b1;
      if (fall_i) begin
        if (acq_pend_q) begin
          acq_o      <= 1'b1;
          acq_pend_q <= 1'b0;
        end
        if (load_pend_q) begin
          busy_o      <= 1'b0;
          load_pend_q <= 1'b0;
          sh_q <= mode8_q ? {result_i[RES_W-1 -: LOW_W], {(RES_W-LOW_W){1'b0}}}
                          : result_i;
        end else begin
          sh_q <= {sh_q[RES_W-2:0], 1'b0};
        end
        if (done_pend_q) begin
          acq_o       <= 1'b0;
          busy_o      <= 1'b1;
          done_pend_q <= 1'b0;
          load_pend_q <= 1'b1;
          mode8_q     <= mode8_i;
          conv_cnt_q  <= mode8_i ? CW'(LOW_W) : CW'(RES_W);
        end else if (conv_cnt_q != '0) begin
          conv_cnt_q <= conv_cnt_q - 1'b1;
        end
      end
    end
  end

  assign dout_o = sh_q[RES_W-1];
  assign conv_o = (conv_cnt_q != '0);
endmodule

// File: rtl/tsc_serial_port.sv
module tsc_serial_port
  import tsp_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int LOW_W       = 8,
  parameter int ACQ_CLKS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             dclk_i,
  input  logic             din_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             busy_o,
  output logic             busy_oe_o,
  output logic             acq_o,
  output logic             conv_o,
  output logic [2:0]       chan_o,
  output logic             mode8_o,
  output logic             single_o,
  output logic [1:0]       pd_o
);
  logic rise, fall, cs_s, din_s;
  logic cmd_done, acq_go;
  cmd_t cmd_q;

  tsp_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dclk_i (dclk_i),
    .cs_ni  (cs_ni),
    .din_i  (din_i),
    .rise_o (rise),
    .fall_o (fall),
    .cs_o   (cs_s),
    .din_o  (din_s)
  );

  tsp_cmd_rx #(.RES_W(RES_W), .LOW_W(LOW_W), .ACQ_CLKS(ACQ_CLKS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cs_s),
    .rise_i     (rise),
    .din_i      (din_s),
    .cmd_o      (cmd_q),
    .cmd_done_o (cmd_done),
    .acq_go_o   (acq_go)
  );

  tsp_result_tx #(.RES_W(RES_W), .LOW_W(LOW_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cs_s),
    .fall_i     (fall),
    .acq_go_i   (acq_go),
    .cmd_done_i (cmd_done),
    .mode8_i    (cmd_q.mode8),
    .result_i   (result_i),
    .dout_o     (dout_o),
    .busy_o     (busy_o),
    .acq_o      (acq_o),
    .conv_o     (conv_o)
  );

  assign dout_oe_o = ~cs_s;
  assign busy_oe_o = ~cs_s;
  assign chan_o    = cmd_q.chan;
  assign mode8_o   = cmd_q.mode8;
  assign single_o  = cmd_q.single;
  assign pd_o      = cmd_q.pd;
endmodule

// File: rtl/tsc_serial_port_chk.sv
module tsc_serial_port_chk #(
  parameter int RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             cmd_done,
  input logic             busy_o,
  input logic             acq_o,
  input logic             conv_o,
  input logic             dout_o,
  input logic [RES_W-1:0] result_i,
  input logic [6:0]       fields
);
  // R1
  cs_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (!busy_o && !acq_o && !conv_o));

  // R8
  acq_conv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acq_o && conv_o));

  // R4
  busy_after_acq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $fell(acq_o));

  // R4
  busy_in_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> conv_o);

  // R5
  msb_on_busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(cs_s)) |-> (dout_o == $past(result_i[RES_W-1])));

  // R3
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_done |-> $stable(fields));
endmodule

bind tsc_serial_port tsc_serial_port_chk #(.RES_W(RES_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .cmd_done (cmd_done),
  .busy_o   (busy_o),
  .acq_o    (acq_o),
  .conv_o   (conv_o),
  .dout_o   (dout_o),
  .result_i (result_i),
  .fields   ({chan_o, mode8_o, single_o, pd_o})
);

// File: tb/tsc_serial_port_tb.sv
module tsc_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, dclk = 1'b0, din = 1'b0;
  logic [11:0] result;
  logic dout, dout_oe, busy, busy_oe, acq, conv, mode8, single;
  logic [2:0] chan;
  logic [1:0] pd;

  int checks = 0, errors = 0, idx = 0;
  logic seq    [64];
  logic s_dout [64];
  logic s_busy [64];
  logic s_acq  [64];
  logic s_conv [64];
  logic [6:0] s_cmd [64];

  always #10 clk = ~clk;

  tsc_serial_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .dclk_i(dclk), .din_i(din),
    .result_i(result), .dout_o(dout), .dout_oe_o(dout_oe), .busy_o(busy),
    .busy_oe_o(busy_oe), .acq_o(acq), .conv_o(conv), .chan_o(chan),
    .mode8_o(mode8), .single_o(single), .pd_o(pd)
  );

  // behavioural converter stub
  function automatic logic [11:0] stub(input logic [2:0] ch, input logic se,
                                       input logic [1:0] p);
    return {ch, se, ~ch, p, 3'b101};
  endfunction
  assign result = stub(chan, single, pd);

  function automatic logic [7:0] mk(input logic [2:0] ch, input logic m8,
                                    input logic se, input logic [1:0] p);
    return {1'b1, ch, m8, se, p};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_cycle(input logic d);
    din = d;
    repeat (6) @(negedge clk);
    s_dout[idx] = dout; s_busy[idx] = busy; s_acq[idx] = acq; s_conv[idx] = conv;
    s_cmd[idx]  = {chan, mode8, single, pd};
    dclk = 1'b1;
    repeat (6) @(negedge clk);
    dclk = 1'b0;
    idx++;
  endtask

  task automatic clear_seq();
    for (int k = 0; k < 64; k++) seq[k] = 1'b0;
  endtask

  task automatic put_byte(input int pos, input logic [7:0] b);
    for (int k = 0; k < 8; k++) seq[pos+k] = b[7-k];
  endtask

  task automatic run_seq(input int n);
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    idx = 1;
    for (int k = 1; k <= n; k++) clk_cycle(seq[k]);
    din = 1'b0; cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // checks of one frame whose start bit sits on clock s
  task automatic check_frame(input int s, input logic [7:0] b, input logic zero_tail);
    logic [11:0] r;
    int nb;
    string rd;
    r  = stub(b[6:4], b[2], b[1:0]);
    nb = b[3] ? 8 : 12;
    rd = b[3] ? "R6" : "R5";
    chk(s_cmd[s+8] == b[6:0], "R3 fields", s_cmd[s+8], b[6:0]);
    chk(!s_busy[s+7] && s_busy[s+8] && !s_busy[s+9], "R4 busy window",
        {s_busy[s+7], s_busy[s+8], s_busy[s+9]}, 3'b010);
    for (int j = 0; j < nb; j++)
      chk(s_dout[s+9+j] == r[11-j], rd, s_dout[s+9+j], r[11-j]);
    chk(!s_acq[s+4] && s_acq[s+5] && s_acq[s+7] && !s_acq[s+8], "R8 acq window",
        {s_acq[s+4], s_acq[s+5], s_acq[s+7], s_acq[s+8]}, 4'b0110);
    chk(!s_conv[s+7] && s_conv[s+8] && s_conv[s+7+nb] && !s_conv[s+8+nb], "R8 conv window",
        {s_conv[s+7], s_conv[s+8], s_conv[s+7+nb], s_conv[s+8+nb]}, 4'b0110);
    if (zero_tail)
      chk(s_dout[s+9+nb] == 1'b0 && s_dout[s+10+nb] == 1'b0, "R7 zero tail",
          {s_dout[s+9+nb], s_dout[s+10+nb]}, 0);
  endtask

  task automatic t_reset();
    chk(!dout_oe && !busy_oe, "R1 oe low at reset", {dout_oe, busy_oe}, 0);
    chk(!busy && !acq && !conv, "R1 idle outputs", {busy, acq, conv}, 0);
    chk({chan, mode8, single, pd} == 7'd0, "R3 reset fields", {chan, mode8, single, pd}, 0);
  endtask

  task automatic t_frame24();
    logic [7:0] b = mk(3'b001, 1'b0, 1'b0, 2'b00);
    clear_seq(); put_byte(1, b);
    run_seq(26);
    check_frame(1, b, 1'b1);  // R10 24-clock framing
    chk(!dout_oe && !busy_oe, "R1 oe low after cs", {dout_oe, busy_oe}, 0);
  endtask

  task automatic t_lead8();
    logic [7:0] b = mk(3'b101, 1'b1, 1'b1, 2'b11);
    clear_seq(); put_byte(4, b);  // R2 three leading zeros
    run_seq(30);
    chk(s_busy[11] == 1'b0 && s_busy[12] == 1'b1, "R2 start found late",
        {s_busy[11], s_busy[12]}, 2'b01);
    check_frame(4, b, 1'b1);
  endtask

  task automatic t_back15();
    logic [7:0] b1 = mk(3'b011, 1'b0, 1'b1, 2'b01);
    logic [7:0] b2 = mk(3'b110, 1'b0, 1'b0, 2'b10);
    clear_seq(); put_byte(1, b1); put_byte(16, b2);
    seq[10] = 1'b1; seq[15] = 1'b1;  // R9 early ones ignored
    run_seq(40);
    check_frame(1, b1, 1'b0);
    chk(s_cmd[23] == b1[6:0], "R3 fields held", s_cmd[23], b1[6:0]);
    check_frame(16, b2, 1'b1);
    chk(!s_busy[18] && !s_busy[23], "R9 early start ignored", {s_busy[18], s_busy[23]}, 0);
  endtask

  task automatic t_back11();
    logic [7:0] b1 = mk(3'b010, 1'b1, 1'b0, 2'b11);
    logic [7:0] b2 = mk(3'b111, 1'b1, 1'b1, 2'b00);
    clear_seq(); put_byte(1, b1); put_byte(12, b2);
    seq[11] = 1'b1;
    run_seq(32);
    check_frame(1, b1, 1'b0);
    check_frame(12, b2, 1'b1);
    chk(!s_busy[19], "R9 early 8-bit start ignored", s_busy[19], 0);
  endtask

  task automatic t_back16();
    logic [7:0] b1 = mk(3'b100, 1'b0, 1'b0, 2'b01);
    logic [7:0] b2 = mk(3'b001, 1'b0, 1'b1, 2'b10);
    clear_seq(); put_byte(1, b1); put_byte(17, b2);
    run_seq(40);
    check_frame(1, b1, 1'b1);  // R10 16-clock framing
    check_frame(17, b2, 1'b1);
  endtask

  task automatic t_abort();
    logic [7:0] keep = {chan, mode8, single, pd} | 8'h80;
    logic [7:0] b    = mk(3'b110, 1'b0, 1'b1, 2'b11);
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    idx = 1;
    clk_cycle(1'b1); clk_cycle(1'b0); clk_cycle(1'b1); clk_cycle(1'b0); clk_cycle(1'b0);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(!dout_oe && !busy_oe && !busy && !acq, "R1 abort clears",
        {dout_oe, busy_oe, busy, acq}, 0);
    chk({chan, mode8, single, pd} == keep[6:0], "R3 held over cs",
        {chan, mode8, single, pd}, keep[6:0]);
    clear_seq(); put_byte(1, b);
    run_seq(26);
    check_frame(1, b, 1'b1);  // R1 fresh start after abort
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frame24();
    t_lead8();
    t_back15();
    t_back11();
    t_back16();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule